// File: doc/BRIEF.md
# Overcurrent Alarm Conditioner

This block takes an external overcurrent alarm pin, which arrives with no relation to the clock. It turns the pin into two outputs: a clock-domain throttle request, and a single-cycle interrupt pulse that is raised according to how many alarm events have been seen. The pin passes through a two-flop synchronizer. It is then corrected for polarity, and every inactive-to-active transition counts as one alarm event.

Events increment a counter. The interrupt mode can be off, fire on every event, or fire when the count reaches a programmed threshold. An idle filter counts clock cycles since the most recent event and clears the count when the programmed number of cycles passes with no new event. The throttle request follows the synchronized alarm. After the alarm ends, the request stays asserted for a programmed number of microseconds, which are counted from a 1 MHz tick supplied by the surrounding chip.

The configuration inputs are meant to be static. Software changes them only while the block is held in reset.

Top module: `ocg_top`

## Requirements
- R1: With `cfg_active_low` = 0 the pin is active when high; with `cfg_active_low` = 1 it is active when low. A pin that stays at its inactive level produces no throttle request and no interrupt.
- R2: The pin passes through two synchronizer flops. `throttle_req` rises after the second rising clock edge that follows the pin becoming active, and not after the first.
- R3: With `cfg_irq_mode` = 2'b00 or 2'b11, `irq_pulse` never asserts, however many events occur.
- R4: With `cfg_irq_mode` = 2'b01, every event produces an `irq_pulse` that is high for exactly one cycle, after the third rising edge following the pin becoming active.
- R5: With `cfg_irq_mode` = 2'b10, `irq_pulse` fires on the event that brings the count to `cfg_threshold`, and the count then restarts from zero. A threshold of 0 behaves like a threshold of 1.
- R6: With `cfg_filter` = F > 0, the count is cleared when F clock cycles pass after an event without a further event. An event that lands exactly on the expiry cycle is counted rather than lost, and every event reloads the filter.
- R7: With `cfg_filter` = 0, the count is never cleared by idle time.
- R8: After the synchronized alarm ends, `throttle_req` stays high until `cfg_hold_us` rising edges of `us_tick` have been sampled. With `cfg_hold_us` = 0 it falls together with the alarm. Idle cycles without a tick do not shorten the hold.
- R9: Ticks that arrive while the alarm is active do not consume hold time, because the hold timer reloads to `cfg_hold_us` on every active cycle.
- R10: In reset and right after it, `throttle_req` and `irq_pulse` are low and the event count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_pin | input | 1 | Raw asynchronous overcurrent alarm |
| cfg_active_low | input | 1 | 1 selects an active-low pin |
| cfg_irq_mode | input | 2 | 00 off, 01 every event, 10 threshold, 11 off |
| cfg_threshold | input | CNT_W | Event count that raises the interrupt |
| cfg_filter | input | FILT_W | Idle clocks before the count clears; 0 disables clearing |
| cfg_hold_us | input | HOLD_W | Microseconds of throttle after the alarm ends |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| throttle_req | output | 1 | Throttle request |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with CNT_W = 4, FILT_W = 6 and HOLD_W = 4. With these widths it can sweep every threshold from 0 to 5 against a fixed train of events and compare the number of interrupts against a division done in the bench. It can also step the event spacing across both sides of each filter length, including the exact expiry cycle. Every hold length from 0 to 4 is walked one tick at a time, with ticks also sent while the alarm is active, and both pin polarities are covered.

// File: rtl/ocg_pkg.sv
`timescale 1ns/1ps
package ocg_pkg;

    typedef enum logic [1:0] {
        IRQ_OFF    = 2'b00,
        IRQ_EVERY  = 2'b01,
        IRQ_THRESH = 2'b10,
        IRQ_RSVD   = 2'b11
    } irq_mode_e;

    typedef struct packed {
        logic active;
        logic rise;
    } alarm_s;

    function automatic logic irq_enabled(input irq_mode_e m);
        return (m == IRQ_EVERY) || (m == IRQ_THRESH);
    endfunction

endpackage

// File: rtl/ocg_alarm_sync.sv
`timescale 1ns/1ps
module ocg_alarm_sync
    import ocg_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin,
    input  logic   active_low,
    output alarm_s alarm
);
    logic [SYNC_N-1:0] sync_q;
    logic              act_q;
    logic              act;

    // Reset the synchronizer to the inactive pin level so no false edge follows reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= {SYNC_N{active_low}};
            act_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin};
            act_q  <= act;
        end
    end

    always_comb begin
        act          = sync_q[SYNC_N-1] ^ active_low;
        alarm.active = act;
        alarm.rise   = act & ~act_q;
    end

    // R2: an edge is a single-cycle event
    p_rise_single_r2: assert property (@(posedge clk) disable iff (rst)
        alarm.rise |=> !alarm.rise);

endmodule

// File: rtl/ocg_event_count.sv
`timescale 1ns/1ps
module ocg_event_count
    import ocg_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int FILT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  irq_mode_e         mode,
    input  logic [CNT_W-1:0]  threshold,
    input  logic [FILT_W-1:0] filter,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]  cnt_q;
    logic [FILT_W-1:0] filt_q;
    logic [CNT_W:0]    cnt_inc;
    logic              thr_hit;
    logic              fire;
    logic              expire;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
        thr_hit = cnt_inc >= {1'b0, threshold};
        fire    = rise && irq_enabled(mode) && ((mode == IRQ_EVERY) || thr_hit);
        expire  = (filt_q == FILT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            filt_q <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= fire;
            if (rise) begin
                filt_q <= filter;
                if (fire)
                    cnt_q <= '0;
                else if (cnt_q != CNT_MAX)
                    cnt_q <= cnt_inc[CNT_W-1:0];
            end else begin
                if (filt_q != '0)
                    filt_q <= filt_q - FILT_W'(1);
                if (expire)
                    cnt_q <= '0;
            end
        end
    end

    p_irq_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    p_off_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (rise && !irq_enabled(mode)) |=> !irq);
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt_q == '0));
    p_below_thr_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == IRQ_THRESH && threshold != '0) |-> (cnt_q < threshold));
    p_idle_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (expire && !rise) |=> (cnt_q == '0));
    p_no_filter_r7: assert property (@(posedge clk) disable iff (rst)
        (filter == '0 && filt_q == '0 && !rise) |=> $stable(cnt_q));

endmodule

// File: rtl/ocg_hold_timer.sv
`timescale 1ns/1ps
module ocg_hold_timer #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              us_tick,
    input  logic [HOLD_W-1:0] hold_us,
    output logic              throttle
);
    logic [HOLD_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (active)
            hold_q <= hold_us;
        else if (us_tick && hold_q != '0)
            hold_q <= hold_q - HOLD_W'(1);
    end

    assign throttle = active | (hold_q != '0);

    p_hold_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (!active && !us_tick) |=> $stable(hold_q));
    p_hold_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!active && us_tick && hold_q != '0) |=> (hold_q == $past(hold_q) - HOLD_W'(1)));
    p_hold_reload_r9: assert property (@(posedge clk) disable iff (rst)
        active |=> (hold_q == $past(hold_us)));

endmodule

// File: rtl/ocg_top.sv
`timescale 1ns/1ps
module ocg_top
    import ocg_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int FILT_W = 24,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alarm_pin,
    input  logic              cfg_active_low,
    input  logic [1:0]        cfg_irq_mode,
    input  logic [CNT_W-1:0]  cfg_threshold,
    input  logic [FILT_W-1:0] cfg_filter,
    input  logic [HOLD_W-1:0] cfg_hold_us,
    input  logic              us_tick,
    output logic              throttle_req,
    output logic              irq_pulse
);
    alarm_s alarm;

    ocg_alarm_sync #(.SYNC_N(2)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin        (alarm_pin),
        .active_low (cfg_active_low),
        .alarm      (alarm)
    );

    ocg_event_count #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .rise      (alarm.rise),
        .mode      (irq_mode_e'(cfg_irq_mode)),
        .threshold (cfg_threshold),
        .filter    (cfg_filter),
        .irq       (irq_pulse)
    );

    ocg_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .active   (alarm.active),
        .us_tick  (us_tick),
        .hold_us  (cfg_hold_us),
        .throttle (throttle_req)
    );

    // R1, R10: no request can appear without the synchronized alarm or a running hold
    p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!throttle_req && !irq_pulse));

endmodule

// File: tb/ocg_top_tb.sv
`timescale 1ns/1ps
module ocg_top_tb;
    localparam int CNT_W = 4, FILT_W = 6, HOLD_W = 4;

    logic clk = 1'b0, rst = 1'b1, pin = 1'b0, al = 1'b0, tick = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [CNT_W-1:0] thr = '0;
    logic [FILT_W-1:0] filt = '0;
    logic [HOLD_W-1:0] hold = '0;
    logic thr_req, irq;
    int n_chk = 0, n_fail = 0, irq_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ocg_top #(.CNT_W(CNT_W), .FILT_W(FILT_W), .HOLD_W(HOLD_W)) u_dut (
        .clk(clk), .rst(rst), .alarm_pin(pin), .cfg_active_low(al),
        .cfg_irq_mode(mode), .cfg_threshold(thr), .cfg_filter(filt),
        .cfg_hold_us(hold), .us_tick(tick), .throttle_req(thr_req), .irq_pulse(irq));

    always @(negedge clk) if (!rst && irq) irq_cnt++;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart(input logic a_low, input logic [1:0] m, input int t, input int f, input int h);
        @(negedge clk);
        rst = 1'b1; al = a_low; mode = m; thr = CNT_W'(t); filt = FILT_W'(f);
        hold = HOLD_W'(h); pin = a_low; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        irq_cnt = 0;
    endtask

    task automatic pulse(input int on, input int off);
        pin = ~al;
        repeat (on) @(negedge clk);
        pin = al;
        repeat (off) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        restart(1'b0, 2'b01, 0, 0, 3);
        check("R10 throttle after reset", int'(thr_req), 0);
        check("R10 irq after reset", int'(irq), 0);
        repeat (4) @(negedge clk);
        check("R1 idle pin quiet", int'(thr_req), 0);

        // R2/R4 latency, active-high
        pin = 1'b1;
        @(negedge clk); check("R2 first edge", int'(thr_req), 0); check("R4 irq early", int'(irq), 0);
        @(negedge clk); check("R2 second edge", int'(thr_req), 1); check("R4 irq early2", int'(irq), 0);
        @(negedge clk); check("R4 irq third edge", int'(irq), 1);
        @(negedge clk); check("R4 irq one cycle", int'(irq), 0);
        pin = 1'b0;
        repeat (4) @(negedge clk);

        // R1 active-low polarity
        restart(1'b1, 2'b01, 0, 0, 0);
        repeat (5) @(negedge clk);
        check("R1 active-low idle high", int'(thr_req) + irq_cnt, 0);
        pin = 1'b0;
        repeat (2) @(negedge clk); check("R1 active-low asserts", int'(thr_req), 1);
        pin = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 active-low event irq", irq_cnt, 1);

        // R4 every-event mode count
        restart(1'b0, 2'b01, 3, 0, 0);
        for (int i = 0; i < 5; i++) pulse(1, 3);
        repeat (4) @(negedge clk);
        check("R4 every event", irq_cnt, 5);

        // R3 off modes
        for (int m = 0; m < 4; m += 3) begin
            restart(1'b0, 2'(m), 1, 0, 0);
            for (int i = 0; i < 6; i++) pulse(2, 2);
            repeat (4) @(negedge clk);
            check("R3 irq disabled", irq_cnt, 0);
        end

        // R5 threshold sweep
        for (int t = 0; t < 6; t++) begin
            restart(1'b0, 2'b10, t, 0, 0);
            for (int i = 0; i < 12; i++) pulse(1, 3);
            repeat (4) @(negedge clk);
            check($sformatf("R5 threshold %0d", t), irq_cnt, (t == 0) ? 12 : 12 / t);
        end

        // R6 filter sweep: third event d cycles after second
        for (int f = 3; f <= 5; f += 2) begin
            for (int d = 2; d <= f + 2; d++) begin
                restart(1'b0, 2'b10, 3, f, 0);
                pulse(1, 1);
                pulse(1, d - 1);
                pulse(1, 3);
                repeat (4) @(negedge clk);
                check($sformatf("R6 filter %0d gap %0d", f, d), irq_cnt, (d <= f) ? 1 : 0);
            end
        end

        // R7 filter disabled
        restart(1'b0, 2'b10, 3, 0, 0);
        pulse(1, 1); pulse(1, 59); pulse(1, 3);
        repeat (4) @(negedge clk);
        check("R7 no idle clear", irq_cnt, 1);

        // R8/R9 hold sweep
        for (int h = 0; h <= 4; h++) begin
            restart(1'b0, 2'b00, 0, 0, h);
            pin = 1'b1;
            repeat (3) @(negedge clk);
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            pin = 1'b0;
            @(posedge clk); @(posedge clk); @(negedge clk);
            check($sformatf("R9 hold %0d full after active ticks", h), int'(thr_req), (h != 0) ? 1 : 0);
            repeat (3) @(negedge clk);
            check($sformatf("R8 hold %0d no tick", h), int'(thr_req), (h != 0) ? 1 : 0);
            for (int i = 1; i <= h; i++) begin
                tick = 1'b1; @(negedge clk); tick = 1'b0;
                check($sformatf("R8 hold %0d tick %0d", h, i), int'(thr_req), (i < h) ? 1 : 0);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule